// File: doc/BRIEF.md
# Codec Register Access Arbiter with Frame-Counted Read Timeout

This block sits between a host register port and a serial audio/modem codec link. It decides which software agent may touch codec registers. It watches every codec register read it forwards, and it completes that read itself when the codec stays silent for too long. Software claims the codec by reading a one-bit ownership flag. The flag reads 0 when the codec is free, and the act of reading sets it, so only the first reader sees 0. Hardware drops the flag again once the codec transaction is over.

While a codec read is outstanding, the block counts link frame-start strobes. If the codec answers, its data is passed on as the completion. If the frame budget runs out first, the block issues its own completion with every data bit set and latches a sticky read-timeout flag. The same status register holds a sticky general-purpose-input change flag, which is fed by the link's slot-12 bit 0, and two read-only interrupt summaries for the modem input and output channels. A function-level reset clears the arbitration state but keeps the input-change flag.

Top module: `codec_sema_ctl`

## Requirements
- R1: After the main reset, the ownership register (address 0) reads 00h. Its bits 7:1 always read 0, and bit 0 is the ownership flag.
- R2: A read of address 0 returns the flag's value from before the read and sets the flag to 1 from the next cycle on. A second read therefore returns 01h.
- R3: Writes to address 0 have no effect on the ownership flag, whatever data is written.
- R4: Hardware clears the ownership flag on the clock edge at which a read completion is presented (cpl_valid high) or cod_wr_done is pulsed. A read of address 0 in that same cycle wins and leaves the flag set.
- R5: cod_rd_req starts a codec read when none is pending. If rsp_valid arrives before the timeout, cpl_valid pulses for one cycle in the next cycle and cpl_data carries rsp_data.
- R6: If TIMEOUT_FRAMES frame_start strobes pass while the read is pending with no response (the response does not arrive with the last one either), cpl_valid pulses in the next cycle with cpl_data all ones. The timeout flag in status bit 3 is set in the same cycle.
- R7: rsp_valid while no read is pending is ignored, so a late response produces no completion. cod_rd_req while a read is pending is ignored.
- R8: Status bit 3 (timeout flag) is cleared by writing 1 to it at address 1. A new timeout in the same cycle as the clear wins.
- R9: Status bit 0 (input-change flag) is set in each cycle in which gpi_chg is 1. It is cleared by writing 1 to it at address 1, and a set in the same cycle as the clear wins.
- R10: fn_rst clears the ownership flag, the timeout flag and any pending read. It leaves the input-change flag unchanged. Only rst_n clears that flag.
- R11: Status bit 1 is the OR of mi_sts and status bit 2 is the OR of mo_sts. Both fall to 0 as soon as their inputs clear, and writes do not change them.
- R12: Reads of any address other than 0 and 1 return 00h. Status bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main asynchronous reset, active low |
| fn_rst | input | 1 | Synchronous function-level reset, active high |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| cod_rd_req | input | 1 | Codec register read issued to the link |
| cod_wr_done | input | 1 | Codec register write finished on the link |
| frame_start | input | 1 | One-cycle strobe at each link frame start |
| rsp_valid | input | 1 | Codec read response strobe |
| rsp_data | input | DATA_W | Codec read response data |
| cpl_valid | output | 1 | One-cycle read completion strobe |
| cpl_data | output | DATA_W | Read completion data |
| gpi_chg | input | 1 | Slot-12 bit 0 from the link |
| mi_sts | input | N_IN | Modem input channel interrupt status bits |
| mo_sts | input | N_OUT | Modem output channel interrupt status bits |

## Verification
The bench builds the block with TIMEOUT_FRAMES=4, DATA_W=16, N_IN=3, N_OUT=2 and the combinational summary variant. These values make the exact four-frame boundary reachable in a handful of cycles, along with a response racing the last frame and multi-bit OR summaries. Random traffic overlaps claims, completions, clears, late responses and function resets against a bench-side model of the requirements. Directed sequences pin down the first-reader-wins order, the all-ones dummy completion, and the retention of the input-change flag across a function reset.

// File: rtl/csema_pkg.sv
package csema_pkg;
   // status register bit positions (software decodes these)
   localparam int unsigned ST_GPI_BIT = 0;
   localparam int unsigned ST_MI_BIT  = 1;
   localparam int unsigned ST_MO_BIT  = 2;
   localparam int unsigned ST_TO_BIT  = 3;
   localparam int unsigned REG_W      = 8;

   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_WAIT = 1'b1
   } rd_state_e;
endpackage

// File: rtl/csema_owner.sv
module csema_owner (
   input  logic clk,
   input  logic rst_n,
   input  logic fn_rst,
   input  logic claim,
   input  logic release_i,
   output logic owned
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         owned <= 1'b0;
      else if (fn_rst)    owned <= 1'b0;
      else if (claim)     owned <= 1'b1;
      else if (release_i) owned <= 1'b0;
   end
endmodule

// File: rtl/csema_rd_timer.sv
module csema_rd_timer
   import csema_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned TIMEOUT_FRAMES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fn_rst,
   input  logic              issue,
   input  logic              frame_start,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              cpl_valid,
   output logic [DATA_W-1:0] cpl_data,
   output logic              expire,
   output logic              busy
);
   localparam int unsigned       CNT_W = $clog2(TIMEOUT_FRAMES + 1);
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(TIMEOUT_FRAMES - 1);

   rd_state_e        state_q;
   logic [CNT_W-1:0] frames_q;
   logic             got_rsp;

   assign busy = (state_q == RD_WAIT);

   always_comb begin
      got_rsp = busy && rsp_valid && !fn_rst;
      expire  = busy && !rsp_valid && frame_start && (frames_q == LAST) && !fn_rst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RD_IDLE;
         frames_q  <= '0;
         cpl_valid <= 1'b0;
         cpl_data  <= '0;
      end else if (fn_rst) begin
         state_q   <= RD_IDLE;
         frames_q  <= '0;
         cpl_valid <= 1'b0;
      end else begin
         cpl_valid <= got_rsp || expire;
         if (got_rsp)     cpl_data <= rsp_data;
         else if (expire) cpl_data <= '1;
         if (busy) begin
            if (got_rsp || expire) state_q  <= RD_IDLE;
            else if (frame_start)  frames_q <= frames_q + 1'b1;
         end else if (issue) begin
            state_q  <= RD_WAIT;
            frames_q <= '0;
         end
      end
   end
endmodule

// File: rtl/csema_status.sv
module csema_status #(
   parameter int unsigned N_IN        = 2,
   parameter int unsigned N_OUT       = 2,
   parameter bit          SUMMARY_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fn_rst,
   input  logic             gpi_set,
   input  logic             gpi_clr,
   input  logic             to_set,
   input  logic             to_clr,
   input  logic [N_IN-1:0]  mi_sts,
   input  logic [N_OUT-1:0] mo_sts,
   output logic             gpi_flag,
   output logic             to_flag,
   output logic             mi_int,
   output logic             mo_int
);
   // input-change flag: only the main reset clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gpi_flag <= 1'b0;
      else if (gpi_set) gpi_flag <= 1'b1;
      else if (gpi_clr) gpi_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      to_flag <= 1'b0;
      else if (fn_rst) to_flag <= 1'b0;
      else if (to_set) to_flag <= 1'b1;
      else if (to_clr) to_flag <= 1'b0;
   end

   generate
      if (SUMMARY_REG) begin : g_sum_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mi_int <= 1'b0;
               mo_int <= 1'b0;
            end else begin
               mi_int <= |mi_sts;
               mo_int <= |mo_sts;
            end
         end
      end else begin : g_sum_comb
         assign mi_int = |mi_sts;
         assign mo_int = |mo_sts;
      end
   endgenerate
endmodule

// File: rtl/codec_sema_ctl.sv
module codec_sema_ctl
   import csema_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned TIMEOUT_FRAMES = 4,
   parameter int unsigned N_IN           = 2,
   parameter int unsigned N_OUT          = 2,
   parameter int unsigned ADDR_W         = 2,
   parameter int unsigned OWN_ADDR       = 0,
   parameter int unsigned STAT_ADDR      = 1,
   parameter bit          SUMMARY_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fn_rst,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              cod_rd_req,
   input  logic              cod_wr_done,
   input  logic              frame_start,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              cpl_valid,
   output logic [DATA_W-1:0] cpl_data,
   input  logic              gpi_chg,
   input  logic [N_IN-1:0]   mi_sts,
   input  logic [N_OUT-1:0]  mo_sts
);
   localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OWN_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   generate
      if (TIMEOUT_FRAMES < 1) begin : g_bad_timeout
         $error("TIMEOUT_FRAMES must be at least 1");
      end
      if (DATA_W < 1 || N_IN < 1 || N_OUT < 1) begin : g_bad_width
         $error("DATA_W, N_IN and N_OUT must be at least 1");
      end
      if (OWN_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("OWN_ADDR and STAT_ADDR must differ");
      end
      if (OWN_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("register address does not fit ADDR_W");
      end
   endgenerate

   logic hit_own, hit_stat;
   logic owned, expire, busy;
   logic gpi_flag, to_flag, mi_int, mo_int;
   logic unused_wbits;

   assign hit_own      = (reg_addr == A_OWN);
   assign hit_stat     = (reg_addr == A_STAT);
   assign unused_wbits = ^{reg_wdata[7:4], reg_wdata[2:1]} ^ busy;

   csema_owner u_owner (
      .clk       (clk),
      .rst_n     (rst_n),
      .fn_rst    (fn_rst),
      .claim     (reg_rd && hit_own),
      .release_i (cpl_valid || cod_wr_done),
      .owned     (owned)
   );

   csema_rd_timer #(
      .DATA_W         (DATA_W),
      .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .fn_rst      (fn_rst),
      .issue       (cod_rd_req),
      .frame_start (frame_start),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_data),
      .cpl_valid   (cpl_valid),
      .cpl_data    (cpl_data),
      .expire      (expire),
      .busy        (busy)
   );

   csema_status #(
      .N_IN        (N_IN),
      .N_OUT       (N_OUT),
      .SUMMARY_REG (SUMMARY_REG)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .fn_rst   (fn_rst),
      .gpi_set  (gpi_chg),
      .gpi_clr  (reg_wr && hit_stat && reg_wdata[ST_GPI_BIT]),
      .to_set   (expire),
      .to_clr   (reg_wr && hit_stat && reg_wdata[ST_TO_BIT]),
      .mi_sts   (mi_sts),
      .mo_sts   (mo_sts),
      .gpi_flag (gpi_flag),
      .to_flag  (to_flag),
      .mi_int   (mi_int),
      .mo_int   (mo_int)
   );

   always_comb begin
      reg_rdata = '0;
      if (hit_own) begin
         reg_rdata[0] = owned;
      end else if (hit_stat) begin
         reg_rdata[ST_GPI_BIT] = gpi_flag;
         reg_rdata[ST_MI_BIT]  = mi_int;
         reg_rdata[ST_MO_BIT]  = mo_int;
         reg_rdata[ST_TO_BIT]  = to_flag;
      end
   end
endmodule

// File: rtl/csema_chk.sv
module csema_chk #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned OWN_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fn_rst,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_rdata,
   input logic              cpl_valid,
   input logic [DATA_W-1:0] cpl_data,
   input logic              owned,
   input logic              expire,
   input logic              gpi_chg,
   input logic              gpi_flag,
   input logic              to_flag
);
   localparam logic [ADDR_W-1:0] A_OWN = ADDR_W'(OWN_ADDR);

   // R1
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_OWN) |-> (reg_rdata[7:1] == 7'd0));

   // R2
   claim_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_OWN && !fn_rst) |=> owned);

   // R4
   release_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !(reg_rd && reg_addr == A_OWN)) |=> !owned);

   // R6
   dummy_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cpl_valid && cpl_data == '1 && to_flag));

   // R5
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |=> !cpl_valid);

   // R9
   gpi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gpi_chg |=> gpi_flag);
endmodule

bind codec_sema_ctl csema_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .OWN_ADDR (OWN_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fn_rst    (fn_rst),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .cpl_valid (cpl_valid),
   .cpl_data  (cpl_data),
   .owned     (owned),
   .expire    (expire),
   .gpi_chg   (gpi_chg),
   .gpi_flag  (gpi_flag),
   .to_flag   (to_flag)
);

// File: tb/sim_codec_sema_ctl.sv
`timescale 1ns/1ps
module sim_codec_sema_ctl;
   localparam int DW = 16;
   localparam int TO = 4;
   localparam int NI = 3;
   localparam int NO = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fn_rst, reg_rd, reg_wr, cod_rd_req, cod_wr_done, frame_start, rsp_valid, gpi_chg;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [DW-1:0] rsp_data, cpl_data;
   logic cpl_valid;
   logic [NI-1:0] mi_sts;
   logic [NO-1:0] mo_sts;

   int total = 0;
   int bad = 0;

   // bench model state
   bit m_own, m_busy, m_to, m_gpi, m_cpl;
   int m_cnt;
   logic [DW-1:0] m_cdat;

   always #5 clk = ~clk;

   codec_sema_ctl #(
      .DATA_W(DW), .TIMEOUT_FRAMES(TO), .N_IN(NI), .N_OUT(NO),
      .ADDR_W(2), .OWN_ADDR(0), .STAT_ADDR(1), .SUMMARY_REG(1'b0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .fn_rst(fn_rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cod_rd_req(cod_rd_req), .cod_wr_done(cod_wr_done), .frame_start(frame_start),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cpl_valid(cpl_valid),
      .cpl_data(cpl_data), .gpi_chg(gpi_chg), .mi_sts(mi_sts), .mo_sts(mo_sts)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_rdata(input logic [1:0] a);
      if (a == 2'd0) return {7'd0, m_own};
      if (a == 2'd1) return {4'd0, m_to, |mo_sts, |mi_sts, m_gpi};
      return 8'h00;
   endfunction

   task automatic idle();
      fn_rst = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
      cod_rd_req = 0; cod_wr_done = 0; frame_start = 0; rsp_valid = 0;
      rsp_data = 0; gpi_chg = 0;
   endtask

   // called at a negedge with inputs driven; returns at the next negedge
   task automatic step(input string tag);
      bit n_own, n_busy, n_to, n_gpi, n_cpl, to_set;
      int n_cnt;
      logic [DW-1:0] n_cdat;
      #1;
      if (reg_rd) chk(tag, reg_rdata, exp_rdata(reg_addr));
      n_own = m_own; n_busy = m_busy; n_to = m_to; n_gpi = m_gpi;
      n_cnt = m_cnt; n_cdat = m_cdat; n_cpl = 0; to_set = 0;
      if (fn_rst) begin
         n_busy = 0; n_cnt = 0;
      end else if (m_busy) begin
         if (rsp_valid) begin
            n_cpl = 1; n_cdat = rsp_data; n_busy = 0;
         end else if (frame_start) begin
            if (m_cnt == TO - 1) begin
               n_cpl = 1; n_cdat = '1; n_busy = 0; to_set = 1;
            end else n_cnt = m_cnt + 1;
         end
      end else if (cod_rd_req) begin
         n_busy = 1; n_cnt = 0;
      end
      if (fn_rst) n_own = 0;
      else if (reg_rd && reg_addr == 0) n_own = 1;
      else if (m_cpl || cod_wr_done) n_own = 0;
      if (fn_rst) n_to = 0;
      else if (to_set) n_to = 1;
      else if (reg_wr && reg_addr == 1 && reg_wdata[3]) n_to = 0;
      if (gpi_chg) n_gpi = 1;
      else if (reg_wr && reg_addr == 1 && reg_wdata[0]) n_gpi = 0;
      @(posedge clk); #1;
      m_own = n_own; m_busy = n_busy; m_to = n_to; m_gpi = n_gpi;
      m_cnt = n_cnt; m_cdat = n_cdat; m_cpl = n_cpl;
      chk(tag, cpl_valid, m_cpl);
      if (m_cpl) chk(tag, cpl_data, m_cdat);
      @(negedge clk);
      idle();
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      reg_rd = 1; reg_addr = a; step(tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
      reg_wr = 1; reg_addr = a; reg_wdata = d; step(tag);
   endtask

   task automatic frames(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         frame_start = 1; step(tag);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      idle(); mi_sts = 0; mo_sts = 0;
      m_own = 0; m_busy = 0; m_to = 0; m_gpi = 0; m_cpl = 0; m_cnt = 0; m_cdat = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset values
      reg_addr = 0; #1; chk("R1", reg_rdata, 8'h00);
      reg_addr = 1; #1; chk("R1", reg_rdata, 8'h00);
      @(negedge clk); idle();
      // R12: unmapped address
      rd(2'd2, "R12"); rd(2'd3, "R12");
      // R2: first reader 0, second 1
      rd(2'd0, "R2"); rd(2'd0, "R2");
      // R3: writes ignored
      wr(2'd0, 8'h00, "R3"); rd(2'd0, "R3");
      wr(2'd0, 8'hFF, "R3"); rd(2'd0, "R3");
      // R4: codec write completion frees flag
      cod_wr_done = 1; step("R4"); rd(2'd0, "R4");
      // R5: response within budget (flag owned from previous read)
      cod_rd_req = 1; step("R5");
      frames(2, "R5");
      rsp_valid = 1; rsp_data = 16'h1234; step("R5");
      rd(2'd0, "R4");
      step("R4"); rd(2'd0, "R4");
      // R5: response racing last frame wins
      cod_rd_req = 1; step("R5");
      frames(3, "R5");
      frame_start = 1; rsp_valid = 1; rsp_data = 16'h00A5; step("R5");
      step("R5");
      // R6: timeout with all-ones data
      cod_rd_req = 1; step("R6");
      frames(3, "R6");
      chk("R6", cpl_valid, 1'b0);
      frames(1, "R6");
      chk("R6", cpl_data, 16'hFFFF);
      rd(2'd1, "R6");
      // R7: late response ignored, request while busy ignored
      rsp_valid = 1; rsp_data = 16'h5555; step("R7");
      chk("R7", cpl_valid, 1'b0);
      cod_rd_req = 1; step("R7"); cod_rd_req = 1; frame_start = 1; step("R7");
      frames(3, "R7");
      // R8: timeout flag write-1-clear; zero write keeps it
      wr(2'd1, 8'h00, "R8"); rd(2'd1, "R8");
      wr(2'd1, 8'h08, "R8"); rd(2'd1, "R8");
      // R9: input-change flag
      gpi_chg = 1; step("R9"); rd(2'd1, "R9");
      gpi_chg = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 8'h01; step("R9"); rd(2'd1, "R9");
      wr(2'd1, 8'h01, "R9"); rd(2'd1, "R9");
      // R10: function reset keeps input-change flag
      gpi_chg = 1; step("R10"); rd(2'd0, "R10");
      cod_rd_req = 1; step("R10");
      fn_rst = 1; step("R10");
      rd(2'd0, "R10"); rd(2'd1, "R10");
      frames(5, "R10");
      // R11: summaries read-only and follow inputs
      mi_sts = 3'b010; rd(2'd1, "R11");
      mo_sts = 2'b10; wr(2'd1, 8'h06, "R11"); rd(2'd1, "R11");
      mi_sts = 0; mo_sts = 0; rd(2'd1, "R11");

      // constrained random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         reg_rd      = ($urandom % 5) == 0;
         reg_wr      = !reg_rd && ($urandom % 8) == 0;
         reg_addr    = 2'($urandom % 4);
         reg_wdata   = 8'($urandom);
         cod_rd_req  = ($urandom % 8) == 0;
         cod_wr_done = ($urandom % 20) == 0;
         frame_start = ($urandom % 4) == 0;
         rsp_valid   = ($urandom % 12) == 0;
         rsp_data    = DW'($urandom);
         gpi_chg     = ($urandom % 25) == 0;
         fn_rst      = ($urandom % 150) == 0;
         if (($urandom % 6) == 0) mi_sts = NI'($urandom);
         if (($urandom % 6) == 0) mo_sts = NO'($urandom);
         step("R2/R5 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule